// File: doc/BRIEF.md
# Read-After-Write Interlock for a Five-Stage Pipeline

This block holds the front of a small in-order integer pipeline when the instruction in decode would read a register that an older, still-running instruction has not yet written back. The pipeline has five one-cycle stages: fetch, decode, execute, memory and write-back. Operands are read in decode. Results reach the register file only in write-back. There is no forwarding path, so the interlock is the only thing that keeps results correct.

Each cycle the hazard control compares the two decode source registers with the destinations of the instructions in execute and memory. On a match it freezes the fetch counter and the decode register and puts a bubble into execute. The register file writes before it reads within a cycle, so a producer in write-back needs no stall. A dependent instruction directly after its producer therefore waits two cycles, one two slots behind waits one cycle, and one further back does not wait.

A toy add/subtract/load-immediate datapath sits around the interlock. Its write-back port shows every result in order. Instructions come from an external instruction source that is addressed by the fetch counter.

Top module: `raw_interlock`

## Requirements
- R1: While reset is asserted, stall, bubble and wbEn are 0 and fetchPc is 0.
- R2: A consumer that reads, through either source field, the destination of the instruction directly before it makes stall high for exactly 2 cycles, and never more than 2 in a row.
- R3: A consumer two instructions after its producer (one unrelated instruction between them) makes stall high for exactly 1 cycle.
- R4: A consumer three or more instructions after its producer causes no stall, because a write-back and a decode read in the same cycle give the new value.
- R5: Register 0 always reads as zero, a write to it is discarded, and a dependency on register 0 never stalls.
- R6: In the cycle after a stall cycle, fetchPc keeps its value and the decode instruction is unchanged.
- R7: Each stall cycle puts exactly one bubble into execute in the following cycle. The bubble output is high in that cycle and the bubble writes nothing back.
- R8: Results match strict in-order execution. Instruction bits [13:12] select nop(0), add(1), sub(2) or load-immediate(3). Bits [11:8] are the destination, [7:4] the first source and [3:0] the second source, and the immediate is [7:0] zero-extended. Add and subtract wrap modulo 2^16. wbEn, wbAddr and wbData show every add, sub and load-immediate in program order, including writes to register 0.
- R9: Nops, load-immediates, and instructions whose sources match no in-flight destination never stall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| fetchPc | output | 8 | Address of the instruction being fetched |
| fetchInstr | input | 14 | Instruction at fetchPc |
| stall | output | 1 | Fetch and decode frozen this cycle |
| bubble | output | 1 | Execute holds an injected bubble |
| wbEn | output | 1 | A result is being written back |
| wbAddr | output | 4 | Destination of the write-back |
| wbData | output | 16 | Written-back value |

## Verification
The bench varies the distance between a producer and its consumer from one to four slots. For each distance it routes the dependency through the first source, the second source, or both. A design that compared only one source field, or compared against the wrong stage, would miss stalls and write stale sums, or would add needless stall cycles. Dependencies on register 0 check that a zero destination neither stalls nor changes the register. A chain of back-to-back dependent adds checks that the stall count adds up per pair. A pc that kept running during a stall would skip an instruction, and a bubble that wrote back would add a spurious result. Both show up in the write-back order and in the bubble count.

// File: rtl/ilk_pkg.sv
package ilk_pkg;

  typedef enum logic [1:0] {
    OP_NOP = 2'd0,
    OP_ADD = 2'd1,
    OP_SUB = 2'd2,
    OP_LDI = 2'd3
  } opCode_e;

  // strobes from hazard control to datapath
  typedef struct packed {
    logic holdFront;     // freeze pc and decode register
    logic injectBubble;  // load a no-op into execute
  } ctlStrobe_t;

endpackage

// File: rtl/ilk_regfile.sv
module ilk_regfile #(
  parameter int unsigned AddrW = 4,
  parameter int unsigned DataW = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [AddrW-1:0] wrAddr,
  input  logic [DataW-1:0] wrData,
  input  logic [AddrW-1:0] rdAddrA,
  output logic [DataW-1:0] rdDataA,
  input  logic [AddrW-1:0] rdAddrB,
  output logic [DataW-1:0] rdDataB
);
  localparam int unsigned Depth = 1 << AddrW;

  logic [DataW-1:0] regs [Depth];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < Depth; i++) regs[i] <= '0;
    end else if (wrEn && (wrAddr != '0)) begin
      regs[wrAddr] <= wrData;
    end
  end

  // write happens first in the cycle: a same-cycle read sees new data
  function automatic logic [DataW-1:0] readPort(input logic [AddrW-1:0] addr);
    if (addr == '0)                    return '0;
    else if (wrEn && (wrAddr == addr)) return wrData;
    else                               return regs[addr];
  endfunction

  always_comb begin
    rdDataA = readPort(rdAddrA);
    rdDataB = readPort(rdAddrB);
  end

  AST_ZERO_HELD: assert property (@(posedge clk) disable iff (!rstN)
    regs[0] == '0); // R5
  AST_WRITE_STORED: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && (wrAddr != '0)) |=> (regs[$past(wrAddr)] == $past(wrData))); // R8

endmodule

// File: rtl/ilk_hazard_ctrl.sv
module ilk_hazard_ctrl
  import ilk_pkg::*;
#(
  parameter int unsigned AddrW    = 4,
  parameter int unsigned NumOlder = 2
) (
  input  logic                            clk,
  input  logic                            rstN,
  input  logic                            idValid,
  input  logic                            idUsesSrc,
  input  logic [AddrW-1:0]                idRs1,
  input  logic [AddrW-1:0]                idRs2,
  input  logic [NumOlder-1:0]             olderWen,
  input  logic [NumOlder-1:0][AddrW-1:0]  olderDst,
  output ctlStrobe_t                      ctl
);
  logic [NumOlder-1:0] stageHit;
  logic                rawHit;

  for (genvar g = 0; g < NumOlder; g++) begin : g_cmp
    assign stageHit[g] = olderWen[g] && (olderDst[g] != '0) &&
                         ((olderDst[g] == idRs1) || (olderDst[g] == idRs2));
  end

  assign rawHit           = idValid && idUsesSrc && (|stageHit);
  assign ctl.holdFront    = rawHit;
  assign ctl.injectBubble = rawHit;

  AST_STALL_RUN_MAX2: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.holdFront && $past(ctl.holdFront)) |=> !ctl.holdFront); // R2
  AST_STALL_HAS_PRODUCER: assert property (@(posedge clk) disable iff (!rstN)
    ctl.holdFront |-> (|(olderWen))); // R5
  AST_NO_SRC_NO_STALL: assert property (@(posedge clk) disable iff (!rstN)
    !idUsesSrc |-> !ctl.holdFront); // R9

endmodule

// File: rtl/ilk_datapath.sv
module ilk_datapath
  import ilk_pkg::*;
#(
  parameter int unsigned AddrW = 4,
  parameter int unsigned DataW = 16,
  parameter int unsigned PcW   = 8
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  ctlStrobe_t             ctl,
  output logic [PcW-1:0]         fetchPc,
  input  logic [2+3*AddrW-1:0]   fetchInstr,
  output logic                   idValid,
  output logic                   idUsesSrc,
  output logic [AddrW-1:0]       idRs1,
  output logic [AddrW-1:0]       idRs2,
  output logic                   exWen,
  output logic [AddrW-1:0]       exDst,
  output logic                   memWen,
  output logic [AddrW-1:0]       memDst,
  output logic                   exIsBubble,
  output logic                   wbEn,
  output logic [AddrW-1:0]       wbAddr,
  output logic [DataW-1:0]       wbData
);
  localparam int unsigned InstrW = 2 + 3 * AddrW;
  localparam int unsigned ImmW   = 2 * AddrW;

  // fetch / decode state
  logic [PcW-1:0]    pcQ;
  logic [InstrW-1:0] idInstr;
  logic              idValidQ;

  // decode fields
  opCode_e          idOp;
  logic [AddrW-1:0] idRd;
  logic [DataW-1:0] idA, idB, idImm;
  logic             idWen;

  // execute stage
  logic             exWenQ, exBubbleQ;
  opCode_e          exOp;
  logic [AddrW-1:0] exDstQ;
  logic [DataW-1:0] exA, exB, exImm, exResult;

  // memory and write-back stages
  logic             memWenQ, wbWenQ;
  logic [AddrW-1:0] memDstQ, wbDstQ;
  logic [DataW-1:0] memDataQ, wbDataQ;

  assign idOp      = opCode_e'(idInstr[InstrW-1 -: 2]);
  assign idRd      = idInstr[3*AddrW-1 -: AddrW];
  assign idRs1     = idInstr[2*AddrW-1 -: AddrW];
  assign idRs2     = idInstr[AddrW-1:0];
  assign idImm     = DataW'(idInstr[ImmW-1:0]);
  assign idUsesSrc = idValidQ && ((idOp == OP_ADD) || (idOp == OP_SUB));
  assign idWen     = idValidQ && (idOp != OP_NOP);
  assign idValid   = idValidQ;

  ilk_regfile #(.AddrW(AddrW), .DataW(DataW)) u_rf (
    .clk     (clk),
    .rstN    (rstN),
    .wrEn    (wbWenQ),
    .wrAddr  (wbDstQ),
    .wrData  (wbDataQ),
    .rdAddrA (idRs1),
    .rdDataA (idA),
    .rdAddrB (idRs2),
    .rdDataB (idB)
  );

  // fetch and decode register: frozen while holding
  always_ff @(posedge clk) begin
    if (!rstN) begin
      pcQ      <= '0;
      idInstr  <= '0;
      idValidQ <= 1'b0;
    end else if (!ctl.holdFront) begin
      pcQ      <= pcQ + 1'b1;
      idInstr  <= fetchInstr;
      idValidQ <= 1'b1;
    end
  end

  // decode -> execute, with bubble injection
  always_ff @(posedge clk) begin
    if (!rstN) begin
      exWenQ    <= 1'b0;
      exBubbleQ <= 1'b0;
      exOp      <= OP_NOP;
      exDstQ    <= '0;
      exA       <= '0;
      exB       <= '0;
      exImm     <= '0;
    end else if (ctl.injectBubble) begin
      exWenQ    <= 1'b0;
      exBubbleQ <= 1'b1;
      exOp      <= OP_NOP;
    end else begin
      exWenQ    <= idWen;
      exBubbleQ <= 1'b0;
      exOp      <= idOp;
      exDstQ    <= idRd;
      exA       <= idA;
      exB       <= idB;
      exImm     <= idImm;
    end
  end

  always_comb begin
    unique case (exOp)
      OP_ADD:  exResult = exA + exB;
      OP_SUB:  exResult = exA - exB;
      OP_LDI:  exResult = exImm;
      default: exResult = '0;
    endcase
  end

  // execute -> memory -> write-back
  always_ff @(posedge clk) begin
    if (!rstN) begin
      memWenQ  <= 1'b0;
      memDstQ  <= '0;
      memDataQ <= '0;
      wbWenQ   <= 1'b0;
      wbDstQ   <= '0;
      wbDataQ  <= '0;
    end else begin
      memWenQ  <= exWenQ;
      memDstQ  <= exDstQ;
      memDataQ <= exResult;
      wbWenQ   <= memWenQ;
      wbDstQ   <= memDstQ;
      wbDataQ  <= memDataQ;
    end
  end

  assign fetchPc    = pcQ;
  assign exWen      = exWenQ;
  assign exDst      = exDstQ;
  assign memWen     = memWenQ;
  assign memDst     = memDstQ;
  assign exIsBubble = exBubbleQ;
  assign wbEn       = wbWenQ;
  assign wbAddr     = wbDstQ;
  assign wbData     = wbDataQ;

  AST_PC_FROZEN: assert property (@(posedge clk) disable iff (!rstN)
    ctl.holdFront |=> $stable(pcQ)); // R6
  AST_DECODE_FROZEN: assert property (@(posedge clk) disable iff (!rstN)
    ctl.holdFront |=> $stable(idInstr)); // R6
  AST_BUBBLE_INJECTED: assert property (@(posedge clk) disable iff (!rstN)
    ctl.holdFront |=> (exBubbleQ && !exWenQ)); // R7
  AST_BUBBLE_NO_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    exBubbleQ |=> !memWenQ); // R7

endmodule

// File: rtl/raw_interlock.sv
module raw_interlock
  import ilk_pkg::*;
#(
  parameter int unsigned AddrW = 4,
  parameter int unsigned DataW = 16,
  parameter int unsigned PcW   = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  output logic [PcW-1:0]       fetchPc,
  input  logic [2+3*AddrW-1:0] fetchInstr,
  output logic                 stall,
  output logic                 bubble,
  output logic                 wbEn,
  output logic [AddrW-1:0]     wbAddr,
  output logic [DataW-1:0]     wbData
);
  // stages between operand read (decode) and write-back: execute, memory
  localparam int unsigned NumOlder = 2;

  ctlStrobe_t                        ctl;
  logic                              idValid, idUsesSrc;
  logic [AddrW-1:0]                  idRs1, idRs2;
  logic                              exWen, memWen;
  logic [AddrW-1:0]                  exDst, memDst;
  logic [NumOlder-1:0]               olderWen;
  logic [NumOlder-1:0][AddrW-1:0]    olderDst;

  assign olderWen = {memWen, exWen};
  assign olderDst = {memDst, exDst};

  ilk_hazard_ctrl #(.AddrW(AddrW), .NumOlder(NumOlder)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .idValid   (idValid),
    .idUsesSrc (idUsesSrc),
    .idRs1     (idRs1),
    .idRs2     (idRs2),
    .olderWen  (olderWen),
    .olderDst  (olderDst),
    .ctl       (ctl)
  );

  ilk_datapath #(.AddrW(AddrW), .DataW(DataW), .PcW(PcW)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .ctl        (ctl),
    .fetchPc    (fetchPc),
    .fetchInstr (fetchInstr),
    .idValid    (idValid),
    .idUsesSrc  (idUsesSrc),
    .idRs1      (idRs1),
    .idRs2      (idRs2),
    .exWen      (exWen),
    .exDst      (exDst),
    .memWen     (memWen),
    .memDst     (memDst),
    .exIsBubble (bubble),
    .wbEn       (wbEn),
    .wbAddr     (wbAddr),
    .wbData     (wbData)
  );

  assign stall = ctl.holdFront;

endmodule

// File: tb/sim_raw_interlock.sv
module sim_raw_interlock;
  localparam int AW = 4;
  localparam int DW = 16;
  localparam int IW = 2 + 3 * AW;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [7:0]    fetchPc;
  logic [IW-1:0] fetchInstr;
  logic          stall, bubble, wbEn;
  logic [AW-1:0] wbAddr;
  logic [DW-1:0] wbData;

  logic [IW-1:0] prog [16];
  int            progLen;
  int            nChecks = 0;
  int            nFails  = 0;
  bit            done    = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  raw_interlock u0 (
    .clk(clk), .rstN(rstN), .fetchPc(fetchPc), .fetchInstr(fetchInstr),
    .stall(stall), .bubble(bubble), .wbEn(wbEn), .wbAddr(wbAddr), .wbData(wbData)
  );

  always_comb fetchInstr = (fetchPc < 8'd16) ? prog[fetchPc[3:0]] : '0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic logic [IW-1:0] enc(input int op, input int rd, input int a, input int b);
    return IW'((op << 12) | (rd << 8) | (a << 4) | b);
  endfunction

  function automatic logic [IW-1:0] ldi(input int rd, input int imm);
    return IW'((3 << 12) | (rd << 8) | (imm & 255));
  endfunction

  task automatic clearProg();
    for (int i = 0; i < 16; i++) prog[i] = '0;
    progLen = 0;
  endtask

  task automatic put(input logic [IW-1:0] ins);
    prog[progLen] = ins;
    progLen++;
  endtask

  // run the loaded program and compare against sequential execution
  task automatic runProg(input int expStalls, input string req);
    int model [16];
    int expAddr [16];
    int expData [16];
    int nExp, got, stallCnt, bubCnt, prevPc;
    bit prevStall;
    nExp = 0;
    for (int i = 0; i < 16; i++) model[i] = 0;
    for (int i = 0; i < progLen; i++) begin
      int op, rd, a, b, v;
      op = int'(prog[i][13:12]);
      rd = int'(prog[i][11:8]);
      a  = int'(prog[i][7:4]);
      b  = int'(prog[i][3:0]);
      if (op != 0) begin
        if (op == 1)      v = (model[a] + model[b]) & 16'hFFFF;
        else if (op == 2) v = (model[a] - model[b]) & 16'hFFFF;
        else              v = int'(prog[i][7:0]);
        expAddr[nExp] = rd;
        expData[nExp] = v;
        nExp++;
        if (rd != 0) model[rd] = v;
      end
    end
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    chk(!stall && !bubble && !wbEn && fetchPc == 0, "R1", "reset state",
        int'({stall, bubble, wbEn}) + int'(fetchPc), 0);
    rstN = 1'b1;
    got = 0; stallCnt = 0; bubCnt = 0; prevStall = 1'b0; prevPc = 0;
    repeat (48) begin
      @(negedge clk);
      if (prevStall) chk(int'(fetchPc) == prevPc, "R6", "pc held after stall",
                         int'(fetchPc), prevPc);
      if (stall) stallCnt++;
      if (bubble) bubCnt++;
      if (wbEn) begin
        if (got < nExp) begin
          chk(int'(wbAddr) == expAddr[got], "R8", "write-back address",
              int'(wbAddr), expAddr[got]);
          chk(int'(wbData) == expData[got], "R8", "write-back data",
              int'(wbData), expData[got]);
        end else begin
          chk(1'b0, "R7", "extra write-back", got + 1, nExp);
        end
        got++;
      end
      prevStall = stall;
      prevPc = int'(fetchPc);
    end
    chk(stallCnt == expStalls, req, "stall cycles", stallCnt, expStalls);
    chk(bubCnt == stallCnt, "R7", "bubbles per stall", bubCnt, stallCnt);
    chk(got == nExp, "R8", "write-back count", got, nExp);
  endtask

  initial begin
    // R2: add then dependent subtract, wrapping result
    clearProg();
    put(ldi(1, 7)); put(ldi(2, 20));
    put('0); put('0); put('0);
    put(enc(1, 3, 1, 2));
    put(enc(2, 5, 2, 3));
    runProg(2, "R2");

    // distance / source sweep: R2 (d=1), R3 (d=2), R4 (d>=3)
    for (int d = 1; d <= 4; d++) begin
      for (int s = 0; s < 3; s++) begin
        string tag;
        clearProg();
        put(ldi(1, 9 + d)); put(ldi(2, 4 * s + 1));
        put('0); put('0); put('0);
        put(enc(1, 3, 1, 2));
        for (int k = 1; k < d; k++) put('0);
        if (s == 0)      put(enc(2, 4, 3, 2));
        else if (s == 1) put(enc(2, 4, 1, 3));
        else             put(enc(2, 4, 3, 3));
        tag = (d == 1) ? "R2" : (d == 2) ? "R3" : "R4";
        runProg((d >= 3) ? 0 : 3 - d, tag);
      end
    end

    // R5: register 0 never stalls and reads zero
    for (int d = 1; d <= 2; d++) begin
      clearProg();
      put(ldi(0, 55));
      for (int k = 1; k < d; k++) put('0);
      put(enc(1, 6, 0, 0));
      put(enc(2, 7, 0, 0));
      runProg(0, "R5");
    end

    // R9: no-source instructions and non-matching sources never stall
    clearProg();
    put(ldi(1, 3)); put(ldi(1, 4)); put(ldi(2, 1));
    put(enc(1, 3, 4, 5)); put('0); put(enc(2, 6, 7, 8));
    runProg(0, "R9");

    // R2: chain of back-to-back dependent adds, two stalls per pair
    clearProg();
    put(ldi(1, 1));
    put(enc(1, 1, 1, 1)); put(enc(1, 1, 1, 1)); put(enc(1, 1, 1, 1));
    runProg(6, "R2");

    // R8: subtract wraps modulo 2^16
    clearProg();
    put(ldi(1, 0)); put(ldi(2, 1)); put('0); put('0); put('0);
    put(enc(2, 3, 1, 2));
    runProg(0, "R8");

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual running expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

endmodule